// File: doc/BRIEF.md
# Dual-Path Registered/Transparent Bus Transceiver

This block joins two 18-bit buses, A and B, through two independent storage paths, one for each direction. Each path has its own latch enable, strobe clock, clock enable and output enable. With the latch enable high the path is a plain wire: the far side follows the near side in the same cycle. With it low the path shows its stored word. That word is replaced on a rising edge of the path's strobe, but only while the strobe's enable is active. Data is never inverted.

The strobes, enables and data are sampled on a single system clock `clk_i`. A strobe edge counts when the strobe is low at one `clk_i` edge and high at the next. Three-state pins are split into a data output and a drive-enable output per port. Each input side has a keeper. When no external agent drives a bus, the path reads the last value that was on that bus, whether the external agent or the block itself put it there. Because the keepers are registered, the design has no combinational loop from A back to A, even with both paths transparent and driving.

Top module: `dual_path_xcvr`

## Requirements
- R1: With `ab_le_i`=1 and `a_drv_i`=1, `b_o` equals `a_i` bit for bit, with no inversion, in the same cycle.
- R2: While `ab_le_i`=1 the stored A-to-B word is rewritten from the A side at every `clk_i` edge. After `ab_le_i` falls, `b_o` holds the A-side value present at the last edge where `ab_le_i` was 1.
- R3: With `ab_le_i`=0 and `ab_ce_ni`=0, a strobe edge captures the A-side value into storage, and `b_o` shows it from the next cycle. A strobe edge means `ab_cp_i` was 0 at the previous `clk_i` edge and is 1 at this one.
- R4: With `ab_ce_ni`=1, strobe edges on `ab_cp_i` leave the stored word unchanged.
- R5: With `ab_le_i`=0 and `ab_cp_i` held at either level, the stored word and `b_o` stay unchanged.
- R6: Output enables are active low. `b_oe_o` = NOT `ab_oe_ni` and `a_oe_o` = NOT `ba_oe_ni`. A high enable only releases the drive and does not change the stored word.
- R7: The B-to-A path follows R1 to R5 with `ba_le_i`, `ba_cp_i`, `ba_ce_ni`, `b_i` and `b_drv_i`, and drives `a_o`.
- R8: When a side's drive input (`a_drv_i` or `b_drv_i`) is 0, the path reads that side's keeper. The keeper holds the last value either driven externally or driven by the block's own output on that side. It starts at 0.
- R9: An active `rst_ni`=0 clears both stored words, both keepers and both strobe samplers to 0.
- R10: With both paths transparent, both outputs enabled and both sides driven, `b_o`=`a_i` and `a_o`=`b_i` hold at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Value seen on bus A |
| a_drv_i | input | 1 | An external agent drives bus A |
| a_o | output | 18 | Data this block drives onto bus A |
| a_oe_o | output | 1 | Drive enable for bus A |
| b_i | input | 18 | Value seen on bus B |
| b_drv_i | input | 1 | An external agent drives bus B |
| b_o | output | 18 | Data this block drives onto bus B |
| b_oe_o | output | 1 | Drive enable for bus B |
| ab_oe_ni | input | 1 | A-to-B output enable, active low |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_cp_i | input | 1 | A-to-B capture strobe |
| ab_ce_ni | input | 1 | A-to-B strobe enable, active low |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_cp_i | input | 1 | B-to-A capture strobe |
| ba_ce_ni | input | 1 | B-to-A strobe enable, active low |

## Verification
Some rules are checked by assertions on every cycle: capture after a qualified strobe edge, the hold rule when the strobe is idle or disabled, the transparent bypass, the polarity of the drive enable, and the keeper's stability while nothing drives. Other behaviour only shows up in the bench's scenarios, because it depends on a series of cycles across both paths. That includes a held word surviving a fall of the latch enable, a keeper picking up the block's own driven value and feeding it into the opposite path, and both paths transparent together. The bench runs these against its reference model under random and directed patterns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_CAPT = 2'd2
  } path_mode_e;
endpackage

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         ext_drv_i,
  input  logic [W-1:0] own_i,
  input  logic         own_drv_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (ext_drv_i) hold_q <= pin_i;
    else if (own_drv_i) hold_q <= own_i;
  end

  // external driver wins; registered hold breaks any A->B->A loop
  assign val_o = ext_drv_i ? pin_i : hold_q;

  // R8
  keeper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_drv_i && !own_drv_i) |=> $stable(hold_q));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         le_i,
  input  logic         cp_i,
  input  logic         ce_ni,
  input  logic         oe_ni,
  output logic [W-1:0] dout_o,
  output logic         drive_o
);
  logic         cp_q;
  logic [W-1:0] store_q;
  path_mode_e   mode;

  always_comb begin
    if (le_i)                         mode = MODE_PASS;
    else if (cp_i && !cp_q && !ce_ni) mode = MODE_CAPT;
    else                              mode = MODE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cp_q    <= 1'b0;
      store_q <= '0;
    end else begin
      cp_q <= cp_i;
      if (mode != MODE_HOLD) store_q <= din_i;
    end
  end

  assign dout_o  = le_i ? din_i : store_q;
  assign drive_o = ~oe_ni;

  // R3
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !ce_ni && cp_i && !cp_q) |=> (dout_o == $past(din_i) || le_i));
  // R4 R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && (ce_ni || !cp_i || cp_q)) |=> $stable(store_q));
  // R1
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |-> (dout_o == din_i));
  // R6
  drive_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic         a_drv_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  input  logic         b_drv_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_oe_ni,
  input  logic         ab_le_i,
  input  logic         ab_cp_i,
  input  logic         ab_ce_ni,
  input  logic         ba_oe_ni,
  input  logic         ba_le_i,
  input  logic         ba_cp_i,
  input  logic         ba_ce_ni
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][W-1:0] pin_v, own_v, eff_v, out_v;
  logic [NDIR-1:0]        ext_v, own_drv_v, le_v, cp_v, ce_v, oe_v, drv_v;

  // index 0: A side / A->B path, index 1: B side / B->A path
  assign pin_v     = {b_i, a_i};
  assign ext_v     = {b_drv_i, a_drv_i};
  assign own_v     = {b_o, a_o};
  assign own_drv_v = {b_oe_o, a_oe_o};
  assign le_v      = {ba_le_i, ab_le_i};
  assign cp_v      = {ba_cp_i, ab_cp_i};
  assign ce_v      = {ba_ce_ni, ab_ce_ni};
  assign oe_v      = {ba_oe_ni, ab_oe_ni};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_keeper #(.W(W)) u_keep (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_v[d]),
      .ext_drv_i(ext_v[d]),
      .own_i    (own_v[d]),
      .own_drv_i(own_drv_v[d]),
      .val_o    (eff_v[d])
    );
    xcvr_path #(.W(W)) u_path (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (eff_v[d]),
      .le_i   (le_v[d]),
      .cp_i   (cp_v[d]),
      .ce_ni  (ce_v[d]),
      .oe_ni  (oe_v[d]),
      .dout_o (out_v[d]),
      .drive_o(drv_v[d])
    );
  end

  assign b_o    = out_v[0];
  assign b_oe_o = drv_v[0];
  assign a_o    = out_v[1];
  assign a_oe_o = drv_v[1];

  // R10
  cross_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_le_i && ba_le_i && a_drv_i && b_drv_i) |-> (b_o == a_i && a_o == b_i));
endmodule

// File: tb/dual_path_xcvr_test.sv
module dual_path_xcvr_test;
  localparam int W = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0, a_o, b_o;
  logic a_drv = 0, b_drv = 0, a_oe, b_oe;
  logic ab_oe_n = 1, ab_le = 0, ab_cp = 0, ab_ce_n = 1;
  logic ba_oe_n = 1, ba_le = 0, ba_cp = 0, ba_ce_n = 1;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] st_ab = '0, st_ba = '0, hd_a = '0, hd_b = '0;
  logic cpq_ab = 0, cpq_ba = 0;
  logic [W-1:0] ex_a, ex_b;

  always #5 clk = ~clk;

  dual_path_xcvr #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .a_drv_i(a_drv), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(b_i), .b_drv_i(b_drv), .b_o(b_o), .b_oe_o(b_oe),
    .ab_oe_ni(ab_oe_n), .ab_le_i(ab_le), .ab_cp_i(ab_cp), .ab_ce_ni(ab_ce_n),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_cp_i(ba_cp), .ba_ce_ni(ba_ce_n)
  );

  function automatic logic [W-1:0] path_out(logic le, logic [W-1:0] din, logic [W-1:0] st);
    return le ? din : st;
  endfunction

  function automatic logic [W-1:0] path_next(logic le, logic cp, logic cpq, logic ce_n,
                                             logic [W-1:0] din, logic [W-1:0] st);
    if (le || (cp && !cpq && !ce_n)) return din;
    return st;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // sample after negedge-driven inputs settle, then advance the model at posedge
  task automatic step(string tag);
    logic [W-1:0] ea, eb;
    #1;
    ea = a_drv ? a_i : hd_a;
    eb = b_drv ? b_i : hd_b;
    ex_b = path_out(ab_le, ea, st_ab);
    ex_a = path_out(ba_le, eb, st_ba);
    chk({tag, " b_o"}, b_o, ex_b);
    chk({tag, " a_o"}, a_o, ex_a);
    chk({"R6 b_oe"}, {17'd0, b_oe}, {17'd0, ~ab_oe_n});
    chk({"R6 a_oe"}, {17'd0, a_oe}, {17'd0, ~ba_oe_n});
    @(posedge clk);
    st_ab  = path_next(ab_le, ab_cp, cpq_ab, ab_ce_n, ea, st_ab);
    st_ba  = path_next(ba_le, ba_cp, cpq_ba, ba_ce_n, eb, st_ba);
    cpq_ab = ab_cp;
    cpq_ba = ba_cp;
    hd_a = a_drv ? a_i : (!ba_oe_n ? ex_a : hd_a);
    hd_b = b_drv ? b_i : (!ab_oe_n ? ex_b : hd_b);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state: storage and keepers read zero
    ab_oe_n = 0; ba_oe_n = 0;
    step("R9");
    // R1 transparent
    a_drv = 1; a_i = 18'h2A5C3; ab_le = 1;
    step("R1");
    // R2 falling latch enable keeps last transparent word
    a_i = 18'h15A3C; step("R2");
    ab_le = 0; a_i = 18'h3FFFF; step("R2");
    step("R2");
    // R3 capture on strobe edge
    ab_ce_n = 0; ab_cp = 1; a_i = 18'h01234; step("R3");
    step("R3");
    // R5 strobe held high, then low
    a_i = 18'h0BEEF; step("R5");
    ab_cp = 0; step("R5");
    // R4 disabled strobe edge
    ab_ce_n = 1; ab_cp = 1; step("R4");
    step("R4");
    ab_cp = 0;
    // R8 keeper: A released, own B->A path drives A transparently from B
    a_drv = 0; b_drv = 1; b_i = 18'h2C0DE; ba_le = 1; ab_le = 1; step("R8");
    b_drv = 0; ba_le = 0; step("R8");
    // R10 both transparent, both driven
    a_drv = 1; b_drv = 1; ab_le = 1; ba_le = 1; a_i = 18'h11111; b_i = 18'h22222;
    step("R10");
    // R7 B-to-A capture
    ba_le = 0; ba_ce_n = 0; ba_cp = 1; b_i = 18'h3A5A5; step("R7");
    b_i = 18'h00001; step("R7");
    // R6 released outputs keep stored words
    ab_oe_n = 1; ba_oe_n = 1; ab_le = 0; step("R6");

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      a_i = W'($urandom); b_i = W'($urandom);
      a_drv = ($urandom % 4) != 0; b_drv = ($urandom % 4) != 0;
      ab_le = ($urandom % 5) == 0; ba_le = ($urandom % 5) == 0;
      ab_cp = $urandom % 2; ba_cp = $urandom % 2;
      ab_ce_n = ($urandom % 3) == 0; ba_ce_n = ($urandom % 3) == 0;
      ab_oe_n = ($urandom % 4) == 0; ba_oe_n = ($urandom % 4) == 0;
      step(ab_le ? "R1" : "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule